// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous SRAM

This block is a cycle-accurate, synthesizable model of a synchronous static RAM with a registered read path and a late write path. On each rising clock edge it samples an address, an active-low chip select, an active-low write enable, a burst-continue flag, active-low byte-lane enables and a sleep input. The shared data bus is split into an input `din` and an output `dout` with its own drive enable `dout_en`. An active-low output enable acts on `dout_en` without waiting for a clock edge.

Read data leaves an output register during the cycle that follows the read command. Write data is taken from `din` one edge after the write command. Because of this the bus slot after any command belongs to that command alone, and a write never contends with a read. A read that hits a write still completing on the same edge is served by merging the incoming bytes. A burst starts with a read or a write. It is followed by continue commands that step through four addresses in a ring, and it keeps the direction and byte enables of the command that started it.

Word width is 36 bits (four 9-bit lanes) or 18 bits (two lanes), chosen by a parameter. The depth is `2**ADDR_W` words.

Top module: `lw_sram`

## Requirements
- R1: After reset and before the first read command, `dout_en` is 0 and `dout` is all zeros.
- R2: A read (`sel_n`=0, `wr_n`=1, `cont`=0, `sleep`=0) sampled at edge k drives `dout_en`=1 and `dout` = the stored word at `addr` from edge k until edge k+1, provided `oe_n`=0 and `sleep`=0. Whenever `dout_en` is 0, `dout` is all zeros.
- R3: A write (`sel_n`=0, `wr_n`=0, `cont`=0, `sleep`=0) sampled at edge k takes its data from `din` at edge k+1. Lane i is bits 9i+8 down to 9i. Only lanes whose `ben_n[i]` is 0 are updated, and the other lanes keep their old contents.
- R4: A write with every `ben_n` bit at 1 changes no stored bit, and `dout_en` stays 0 in the following cycle.
- R5: A read sampled on the same edge that a write's data is taken returns that write's enabled lanes from `din`, merged with the stored values of the other lanes.
- R6: A deselect (`sel_n`=1) at edge k gives `dout_en`=0 from edge k to edge k+1.
- R7: In the cycle that follows a write command, `dout_en` is 0, which leaves the bus free for the late data.
- R8: `oe_n`=1 forces `dout_en` to 0 at once. Lowering `oe_n` inside a read's output cycle enables the output without a clock edge.
- R9: `sleep`=1 forces `dout_en` to 0 at once. Commands sampled while `sleep` is 1 are ignored, and stored contents are retained.
- R10: `cont`=1 with `sel_n`=0 after a read or write repeats that command's type and byte enables, and ignores `addr`, `wr_n` and `ben_n`. The address keeps the base's upper bits, and its low two bits are base plus beat count, modulo 4. The fourth continue returns to the base address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the control and output registers |
| sleep | input | 1 | Power-down request; blanks the output and blocks commands |
| sel_n | input | 1 | Active-low select; high means deselect |
| wr_n | input | 1 | Active-low write enable; high means read |
| cont | input | 1 | Burst continue of the last read or write |
| ben_n | input | DATA_W/9 | Active-low byte-lane write enables |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data, sampled one edge after its command |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dout | output | DATA_W | Read data, zero when not driven |
| dout_en | output | 1 | Bus drive enable for `dout` |

## Verification
The bench targets the places where timing and coherence can slip. A read placed right after a write to the same word must see the new bytes. A model without the bypass would return stale data there, and a model with a full-word bypass would corrupt the lanes that were not enabled. Aborted writes are followed by a read of the same word, which exposes a bypass or a memory update that ignores the all-high enables. A four-beat write burst that starts at a base whose low bits are not zero is read back with one continue too many. This catches a missing wrap, a carry into the upper address bits, and a continue that takes its direction from `wr_n` instead of the initiating command. The output enable and sleep are toggled in the middle of a cycle, so an implementation that registers them would lag by one cycle and be caught.

// File: rtl/lw_sram_pkg.sv
`timescale 1ns/1ps
package lw_sram_pkg;
    localparam int LANE_W = 9;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;
endpackage

// File: rtl/lw_sram_ctrl.sv
`timescale 1ns/1ps
module lw_sram_ctrl
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep,
    input  logic              sel_n,
    input  logic              wr_n,
    input  logic              cont,
    input  logic [LANES-1:0]  ben_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              rd_go,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_commit,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [LANES-1:0]  wr_ben_n
);
    localparam int HI_W = ADDR_W - 2;

    typedef struct packed {
        logic              burst_act;
        logic              burst_wr;
        logic [LANES-1:0]  burst_ben_n;
        logic [ADDR_W-1:0] base;
        logic [1:0]        beat;
        logic              pw_vld;
        logic [ADDR_W-1:0] pw_addr;
        logic [LANES-1:0]  pw_ben_n;
    } ctrl_st_t;

    ctrl_st_t          st_d, st_q;
    op_e               op;
    logic [ADDR_W-1:0] cur_addr;
    logic [LANES-1:0]  cur_ben_n;
    logic [1:0]        low_sum;
    logic [HI_W-1:0]   base_hi;

    always_comb begin
        st_d      = st_q;
        op        = OP_IDLE;
        cur_addr  = addr;
        cur_ben_n = ben_n;
        low_sum   = 2'd0;
        base_hi   = st_q.base[ADDR_W-1:2];
        st_d.pw_vld = 1'b0;

        if (sleep || sel_n) begin
            st_d.burst_act = 1'b0;
        end else if (cont) begin
            if (st_q.burst_act) begin
                st_d.beat = st_q.beat + 2'd1;
                low_sum   = st_q.base[1:0] + st_d.beat;
                cur_addr  = {base_hi, low_sum};
                cur_ben_n = st_q.burst_ben_n;
                op        = st_q.burst_wr ? OP_WRITE : OP_READ;
            end
        end else begin
            st_d.burst_act   = 1'b1;
            st_d.burst_wr    = ~wr_n;
            st_d.burst_ben_n = ben_n;
            st_d.base        = addr;
            st_d.beat        = 2'd0;
            op               = wr_n ? OP_READ : OP_WRITE;
        end

        if (op == OP_WRITE) begin
            st_d.pw_vld   = 1'b1;
            st_d.pw_addr  = cur_addr;
            st_d.pw_ben_n = cur_ben_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_go     = (op == OP_READ);
    assign rd_addr   = cur_addr;
    assign wr_commit = st_q.pw_vld;
    assign wr_addr   = st_q.pw_addr;
    assign wr_ben_n  = st_q.pw_ben_n;
endmodule

// File: rtl/lw_sram_array.sv
`timescale 1ns/1ps
module lw_sram_array
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic                     clk,
    input  logic                     wr_commit,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [LANES-1:0]         wr_ben_n,
    input  logic [LANES*LANE_W-1:0]  din,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [LANES*LANE_W-1:0]  rd_word
);
    localparam int DEPTH = 1 << ADDR_W;

    logic hit;
    assign hit = wr_commit && (wr_addr == rd_addr);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];
        logic              lane_we;

        assign lane_we = wr_commit && !wr_ben_n[g];

        always_ff @(posedge clk) begin
            if (lane_we) begin
                lane_mem[wr_addr] <= din[g*LANE_W +: LANE_W];
            end
        end

        assign rd_word[g*LANE_W +: LANE_W] = (hit && !wr_ben_n[g])
                                           ? din[g*LANE_W +: LANE_W]
                                           : lane_mem[rd_addr];
    end
endmodule

// File: rtl/lw_sram_outreg.sv
`timescale 1ns/1ps
module lw_sram_outreg #(
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_go,
    input  logic [DATA_W-1:0] rd_word,
    input  logic              oe_n,
    input  logic              sleep,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);
    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } out_st_t;

    out_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = rd_go;
        if (rd_go) begin
            st_d.data = rd_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout_en = st_q.vld && !oe_n && !sleep;
    assign dout    = dout_en ? st_q.data : '0;
endmodule

// File: rtl/lw_sram.sv
`timescale 1ns/1ps
module lw_sram
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter bit WIDE   = 1'b1,
    localparam int LANES  = WIDE ? 4 : 2,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep,
    input  logic              sel_n,
    input  logic              wr_n,
    input  logic              cont,
    input  logic [LANES-1:0]  ben_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              oe_n,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);
    logic              rd_go;
    logic [ADDR_W-1:0] rd_addr;
    logic              wr_commit;
    logic [ADDR_W-1:0] wr_addr;
    logic [LANES-1:0]  wr_ben_n;
    logic [DATA_W-1:0] rd_word;

    lw_sram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep     (sleep),
        .sel_n     (sel_n),
        .wr_n      (wr_n),
        .cont      (cont),
        .ben_n     (ben_n),
        .addr      (addr),
        .rd_go     (rd_go),
        .rd_addr   (rd_addr),
        .wr_commit (wr_commit),
        .wr_addr   (wr_addr),
        .wr_ben_n  (wr_ben_n)
    );

    lw_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES)) u_array (
        .clk       (clk),
        .wr_commit (wr_commit),
        .wr_addr   (wr_addr),
        .wr_ben_n  (wr_ben_n),
        .din       (din),
        .rd_addr   (rd_addr),
        .rd_word   (rd_word)
    );

    lw_sram_outreg #(.DATA_W(DATA_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_go   (rd_go),
        .rd_word (rd_word),
        .oe_n    (oe_n),
        .sleep   (sleep),
        .dout    (dout),
        .dout_en (dout_en)
    );
endmodule

// File: rtl/lw_sram_chk.sv
`timescale 1ns/1ps
module lw_sram_chk (
    input logic clk,
    input logic rst_n,
    input logic sleep,
    input logic sel_n,
    input logic wr_n,
    input logic cont,
    input logic oe_n,
    input logic dout_en,
    input logic wr_commit
);
    // R9
    sleep_blanks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !dout_en);

    // R8
    oe_blanks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dout_en);

    // R6
    deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n && !sleep) |=> !dout_en);

    // R7
    write_slot_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && !wr_n && !cont && !sleep) |=> !dout_en);

    // R2
    read_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && wr_n && !cont && !sleep) |=> (dout_en || oe_n || sleep));

    // R3
    late_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> $past(!sel_n && !sleep));
endmodule

bind lw_sram lw_sram_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep     (sleep),
    .sel_n     (sel_n),
    .wr_n      (wr_n),
    .cont      (cont),
    .oe_n      (oe_n),
    .dout_en   (dout_en),
    .wr_commit (wr_commit)
);

// File: tb/tb_lw_sram.sv
`timescale 1ns/1ps
module tb_lw_sram;
    localparam int AW = 6;
    localparam int DW = 36;
    localparam int LN = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sleep = 1'b0;
    logic          sel_n = 1'b1;
    logic          wr_n = 1'b1;
    logic          cont = 1'b0;
    logic [LN-1:0] ben_n = '1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic          oe_n = 1'b0;
    logic [DW-1:0] dout;
    logic          dout_en;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    lw_sram #(.ADDR_W(AW), .WIDE(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .sel_n(sel_n), .wr_n(wr_n),
        .cont(cont), .ben_n(ben_n), .addr(addr), .din(din), .oe_n(oe_n),
        .dout(dout), .dout_en(dout_en)
    );

    typedef struct packed {
        logic          sel_n;
        logic          wr_n;
        logic [LN-1:0] ben_n;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          exp_en;
        logic [DW-1:0] exp_q;
        logic [7:0]    req;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 4'b0000, 6'd5, 36'h123456789, 1'b0, 36'h000000000, 8'd3}, // R3 full write
        '{1'b0, 1'b1, 4'b1111, 6'd5, 36'h000000000, 1'b1, 36'h123456789, 8'd5}, // R5 bypass
        '{1'b0, 1'b0, 4'b1110, 6'd5, 36'h0000001FF, 1'b0, 36'h000000000, 8'd7}, // R7 lane 0
        '{1'b0, 1'b1, 4'b1111, 6'd5, 36'h000000000, 1'b1, 36'h1234567FF, 8'd3}, // R3 merge
        '{1'b0, 1'b0, 4'b1111, 6'd5, 36'hAAAAAAAAA, 1'b0, 36'h000000000, 8'd4}, // R4 abort
        '{1'b0, 1'b1, 4'b1111, 6'd5, 36'h000000000, 1'b1, 36'h1234567FF, 8'd4}, // R4 unchanged
        '{1'b1, 1'b1, 4'b1111, 6'd5, 36'h000000000, 1'b0, 36'h000000000, 8'd6}, // R6 deselect
        '{1'b0, 1'b1, 4'b1111, 6'd5, 36'h000000000, 1'b1, 36'h1234567FF, 8'd2}, // R2 read
        '{1'b0, 1'b0, 4'b0111, 6'd5, 36'h000000000, 1'b0, 36'h000000000, 8'd7}, // R7 lane 3
        '{1'b0, 1'b1, 4'b1111, 6'd5, 36'h000000000, 1'b1, 36'h0034567FF, 8'd3}  // R3 lane 3 cleared
    };

    task automatic check(input string req, input logic exp_en, input logic [DW-1:0] exp_q);
        checks++;
        if (dout_en !== exp_en || dout !== exp_q) begin
            errors++;
            $display("FAIL %s: dout_en=%b dout=%h expected dout_en=%b dout=%h",
                     req, dout_en, dout, exp_en, exp_q);
        end
    endtask

    // Apply a command, let one rising edge sample it, stop 1 ns into the next cycle.
    task automatic cmd(input logic s_n, input logic w_n, input logic c,
                       input logic [LN-1:0] b_n, input logic [AW-1:0] a,
                       input logic [DW-1:0] d);
        sel_n = s_n; wr_n = w_n; cont = c; ben_n = b_n; addr = a; din = d;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [DW-1:0] prev_w;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        // R1 reset state
        check("R1", 1'b0, '0);

        // Table walk
        prev_w = '0;
        for (int i = 0; i < NV; i++) begin
            cmd(VEC[i].sel_n, VEC[i].wr_n, 1'b0, VEC[i].ben_n, VEC[i].addr, prev_w);
            prev_w = VEC[i].wdata;
            check($sformatf("R%0d row %0d", VEC[i].req, i), VEC[i].exp_en, VEC[i].exp_q);
        end
        cmd(1'b1, 1'b1, 1'b0, 4'b1111, 6'd0, prev_w);

        // R8 asynchronous output enable
        cmd(1'b0, 1'b0, 1'b0, 4'b0000, 6'd2, '0);
        oe_n = 1'b1;
        cmd(1'b0, 1'b1, 1'b0, 4'b1111, 6'd2, 36'h0ABCDEF01);
        check("R8 oe high", 1'b0, '0);
        #1;
        oe_n = 1'b0;
        #1;
        check("R8 oe low mid-cycle", 1'b1, 36'h0ABCDEF01);

        // R9 sleep blanks at once, blocks commands, keeps data
        cmd(1'b0, 1'b1, 1'b0, 4'b1111, 6'd2, '0);
        check("R9 read before sleep", 1'b1, 36'h0ABCDEF01);
        sleep = 1'b1;
        #1;
        check("R9 sleep mid-cycle", 1'b0, '0);
        cmd(1'b0, 1'b0, 1'b0, 4'b0000, 6'd2, '0);
        cmd(1'b0, 1'b1, 1'b0, 4'b1111, 6'd2, 36'h000000000);
        sleep = 1'b0;
        #1;
        check("R9 read while asleep ignored", 1'b0, '0);
        cmd(1'b0, 1'b1, 1'b0, 4'b1111, 6'd2, '0);
        check("R9 contents retained", 1'b1, 36'h0ABCDEF01);

        // R6 deselect after read
        cmd(1'b1, 1'b1, 1'b0, 4'b1111, 6'd2, '0);
        check("R6 deselect after read", 1'b0, '0);

        // R10 write burst from base 9: beats 9,10,11,8
        cmd(1'b0, 1'b0, 1'b0, 4'b0000, 6'd9, '0);
        cmd(1'b0, 1'b1, 1'b1, 4'b1111, 6'd63, 36'h011110000);
        check("R10 write continue keeps bus free", 1'b0, '0);
        cmd(1'b0, 1'b1, 1'b1, 4'b1111, 6'd63, 36'h011110001);
        cmd(1'b0, 1'b1, 1'b1, 4'b1111, 6'd63, 36'h011110002);
        cmd(1'b1, 1'b1, 1'b0, 4'b1111, 6'd0,  36'h011110003);

        // R10 read burst from base 9 with a fourth continue
        cmd(1'b0, 1'b1, 1'b0, 4'b1111, 6'd9, '0);
        check("R10 beat0 addr 9", 1'b1, 36'h011110000);
        cmd(1'b0, 1'b0, 1'b1, 4'b0000, 6'd0, '0);
        check("R10 beat1 addr 10", 1'b1, 36'h011110001);
        cmd(1'b0, 1'b0, 1'b1, 4'b0000, 6'd0, '0);
        check("R10 beat2 addr 11", 1'b1, 36'h011110002);
        cmd(1'b0, 1'b0, 1'b1, 4'b0000, 6'd0, '0);
        check("R10 beat3 wraps to 8", 1'b1, 36'h011110003);
        cmd(1'b0, 1'b0, 1'b1, 4'b0000, 6'd0, '0);
        check("R10 fourth continue back to base", 1'b1, 36'h011110000);
        cmd(1'b0, 1'b1, 1'b0, 4'b1111, 6'd8, '0);
        check("R10 addr 8 direct", 1'b1, 36'h011110003);
        cmd(1'b1, 1'b1, 1'b0, 4'b1111, 6'd0, '0);
        check("R6 final deselect", 1'b0, '0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule